// File: doc/BRIEF.md
# Splittable Dual 32-bit Timer

A memory-mapped count-up timer that, when its global mode field selects split operation, behaves as two independent 32-bit timers, a lower half and an upper half. Each half owns a counter register, a period register, a two-bit enable field inside a shared control word, and an interrupt line that pulses for one clock when the counter meets its period. Each half stays frozen until software sets its own release bit in the global control register.

Software programs a half by writing its counter (normally to zero) and its period, then writing an enable mode: one-shot stops after the first match and returns the enable field to disabled, and periodic reloads the counter to zero and keeps running. A period of all ones gives a free-running 32-bit counter that wraps from 2^32-1 to 0. Only the internal clock is used. The mode field decodes all four settings, but only the split setting makes the halves count.

Top module: `split_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and both interrupt lines are low.
- R2: Register offsets: lower counter 0x10, upper counter 0x14, lower period 0x18, upper period 0x1C, control 0x20, global control 0x24. Period and global control (bits 3:0) read back what was written. A write to any other offset changes no register, and a read of any other offset returns zero.
- R3: A half counts only when its release bit is 1 (global control bit 0 for the lower half, bit 1 for the upper half) and the mode field (global control bits 3:2) equals 1. Mode 0 selects 64-bit general purpose, 2 selects 64-bit watchdog and 3 selects chained 32-bit; in those modes, or while the release bit is 0, the counter holds its value and the interrupt stays low.
- R4: In periodic mode (enable value 2), the clock edge after the counter equals the period reloads the counter to 0 and raises that half's interrupt for one cycle.
- R5: In one-shot mode (enable value 1), the clock edge after the counter equals the period raises the interrupt for one cycle, sets the enable field to 0 (disabled) and leaves the counter at the period value.
- R6: With a period of 0xFFFFFFFF, the counter steps from 0xFFFFFFFF to 0 and keeps counting.
- R7: A bus write to a counter register loads that value, and a read returns the live count.
- R8: The lower enable field is control bits 7:6 and the upper one is bits 23:22. The other control bits read as zero, and an enable value of 0 or 3 stops the count.
- R9: The two halves run independently: settings and activity of one half never change the other half's counter or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_lo | output | 1 | Lower half match pulse |
| irq_hi | output | 1 | Upper half match pulse |

## Verification
A write takes effect on the edge that samples it, and the counter first steps on the following edge. For period P starting from zero, the interrupt is therefore high in the cycle after edge P+1 counted from the enabling write, and in one-shot mode the enable field reads as disabled at that same point. Each scenario task drives inputs on the falling edge and advances a precise number of falling edges before it samples, so every check lands in the cycle the count predicts. It also checks the cycle after, to confirm that the pulse lasts one cycle and that the count holds or reloads as required.

// File: rtl/split_timer_pkg.sv
// Shared encodings and register offsets for the splittable timer.
package split_timer_pkg;

    typedef enum logic [1:0] {
        RUN_OFF      = 2'd0,
        RUN_ONESHOT  = 2'd1,
        RUN_PERIODIC = 2'd2,
        RUN_RSVD     = 2'd3
    } run_mode_e;

    localparam logic [1:0] GMODE_WIDE_GP  = 2'd0;
    localparam logic [1:0] GMODE_SPLIT    = 2'd1;
    localparam logic [1:0] GMODE_WATCHDOG = 2'd2;
    localparam logic [1:0] GMODE_CHAINED  = 2'd3;

    localparam logic [7:0] OFS_CNT_LO = 8'h10;
    localparam logic [7:0] OFS_CNT_HI = 8'h14;
    localparam logic [7:0] OFS_PRD_LO = 8'h18;
    localparam logic [7:0] OFS_PRD_HI = 8'h1C;
    localparam logic [7:0] OFS_CTRL   = 8'h20;
    localparam logic [7:0] OFS_GCTL   = 8'h24;

endpackage

// File: rtl/split_timer_half.sv
// One 32-bit half: counter with one-shot or periodic match handling.
// Assumes the period and enable mode come from the register bank, and that
// a bus write to the counter wins over counting in the same cycle.
module split_timer_half
    import split_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_i,
    input  run_mode_e        mode_i,
    input  logic [CNT_W-1:0] prd_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             run;
    logic             hit;

    // Counting is allowed only when released and in a counting mode.
    assign run    = gate_i && (mode_i == RUN_ONESHOT || mode_i == RUN_PERIODIC);
    assign hit    = run && (cnt_q == prd_i);
    assign done_o = hit && (mode_i == RUN_ONESHOT);
    assign cnt_o  = cnt_q;

    // Counter update: bus load, reload, hold or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr_i) begin
            cnt_q <= wdata_i;
        end else if (hit) begin
            if (mode_i == RUN_PERIODIC) cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Interrupt pulse registered from the match.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= hit;
    end

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr_i) |=> (cnt_q == $past(cnt_q)));             // R3
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> !irq_o);                                          // R3
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode_i == RUN_PERIODIC && !cnt_wr_i) |=> (cnt_q == '0 && irq_o)); // R4
    AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !cnt_wr_i) |=> (cnt_q == $past(prd_i) && irq_o));  // R5

endmodule

// File: rtl/split_timer_regs.sv
// Register bank: decodes bus writes, stores periods, enable fields and the
// global control, clears an enable field on one-shot completion, and
// muxes read data. Assumes a single-cycle write strobe and combinational reads.
module split_timer_regs
    import split_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int HALVES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [HALVES-1:0][DATA_W-1:0] cnt_i,
    input  logic [HALVES-1:0]        done_i,
    output logic [HALVES-1:0][DATA_W-1:0] prd_o,
    output run_mode_e                mode_o [HALVES],
    output logic [HALVES-1:0]        gate_o,
    output logic [HALVES-1:0]        cnt_wr_o
);

    localparam int EN_LO_POS = 6;
    localparam int EN_HI_POS = 22;

    logic [3:0] gctl_q;
    logic       wr_ctrl;
    logic       wr_gctl;
    logic [DATA_W-1:0] ctrl_view;

    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_gctl = bus_wr && (bus_addr == OFS_GCTL);

    // Global control: release bits and mode field.
    always_ff @(posedge clk) begin
        if (!rst_n)       gctl_q <= '0;
        else if (wr_gctl) gctl_q <= bus_wdata[3:0];
    end

    genvar h;
    generate
        for (h = 0; h < HALVES; h++) begin : g_half
            localparam int EPOS = (h == 0) ? EN_LO_POS : EN_HI_POS;
            localparam logic [7:0] CNT_OFS = (h == 0) ? OFS_CNT_LO : OFS_CNT_HI;
            localparam logic [7:0] PRD_OFS = (h == 0) ? OFS_PRD_LO : OFS_PRD_HI;
            logic [1:0] en_q;

            // Enable field: bus write first, else one-shot completion clears it.
            always_ff @(posedge clk) begin
                if (!rst_n)         en_q <= RUN_OFF;
                else if (wr_ctrl)   en_q <= bus_wdata[EPOS +: 2];
                else if (done_i[h]) en_q <= RUN_OFF;
            end

            // Period register for this half.
            always_ff @(posedge clk) begin
                if (!rst_n)                             prd_o[h] <= '0;
                else if (bus_wr && bus_addr == PRD_OFS) prd_o[h] <= bus_wdata;
            end

            assign mode_o[h]   = run_mode_e'(en_q);
            assign gate_o[h]   = gctl_q[h] && (gctl_q[3:2] == GMODE_SPLIT);
            assign cnt_wr_o[h] = bus_wr && (bus_addr == CNT_OFS);

            AST_ONESHOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (done_i[h] && !wr_ctrl) |=> (en_q == RUN_OFF));     // R5
        end
    endgenerate

    // Control view: only the two enable fields are stored.
    always_comb begin
        ctrl_view = '0;
        ctrl_view[EN_LO_POS +: 2] = g_half[0].en_q;
        ctrl_view[EN_HI_POS +: 2] = g_half[1].en_q;
    end

    // Read multiplexer; undecoded offsets read zero.
    always_comb begin
        case (bus_addr)
            OFS_CNT_LO: bus_rdata = cnt_i[0];
            OFS_CNT_HI: bus_rdata = cnt_i[1];
            OFS_PRD_LO: bus_rdata = prd_o[0];
            OFS_PRD_HI: bus_rdata = prd_o[1];
            OFS_CTRL:   bus_rdata = ctrl_view;
            OFS_GCTL:   bus_rdata = {{(DATA_W-4){1'b0}}, gctl_q};
            default:    bus_rdata = '0;
        endcase
    end

    AST_GCTL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_gctl) |=> $stable(gctl_q));                              // R2

endmodule

// File: rtl/split_timer.sv
// Top: register bank plus two independent 32-bit count-up halves.
// Assumes the internal clock only; no prescaler and no chained operation.
module split_timer
    import split_timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_lo,
    output logic              irq_hi
);

    localparam int HALVES = 2;

    logic [HALVES-1:0][DATA_W-1:0] cnt;
    logic [HALVES-1:0][DATA_W-1:0] prd;
    run_mode_e                     mode [HALVES];
    logic [HALVES-1:0]             gate;
    logic [HALVES-1:0]             cnt_wr;
    logic [HALVES-1:0]             done;
    logic [HALVES-1:0]             irq;

    split_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .HALVES(HALVES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_i(cnt), .done_i(done),
        .prd_o(prd), .mode_o(mode), .gate_o(gate), .cnt_wr_o(cnt_wr)
    );

    genvar h;
    generate
        for (h = 0; h < HALVES; h++) begin : g_tmr
            split_timer_half #(.CNT_W(DATA_W)) u_half (
                .clk(clk), .rst_n(rst_n),
                .gate_i(gate[h]), .mode_i(mode[h]), .prd_i(prd[h]),
                .cnt_wr_i(cnt_wr[h]), .wdata_i(bus_wdata),
                .cnt_o(cnt[h]), .irq_o(irq[h]), .done_o(done[h])
            );
        end
    endgenerate

    assign irq_lo = irq[0];
    assign irq_hi = irq[1];

endmodule

// File: tb/sim_split_timer.sv
module sim_split_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_lo, irq_hi;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    split_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        for (int a = 'h10; a <= 'h24; a += 4) begin
            rd(a[7:0], v);
            check("R1 reg zero", v, 0);
        end
        check("R1 irq_lo", {31'b0, irq_lo}, 0);
        check("R1 irq_hi", {31'b0, irq_hi}, 0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        do_reset();
        wr(8'h18, 32'h1234_5678);
        wr(8'h1C, 32'hCAFE_0001);
        wr(8'h24, 32'hFFFF_FFF5);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h28, 32'hDEAD_BEEF);
        rd(8'h18, v); check("R2 lower period", v, 32'h1234_5678);
        rd(8'h1C, v); check("R2 upper period", v, 32'hCAFE_0001);
        rd(8'h24, v); check("R2 global ctl", v, 32'h5);
        rd(8'h20, v); check("R8 ctrl fields only", v, 32'h00C0_00C0);
        rd(8'h28, v); check("R2 undecoded read", v, 0);
        rd(8'h10, v); check("R2 undecoded write no effect", v, 0);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        do_reset();
        wr(8'h18, 32'd100);
        wr(8'h20, 32'h80);
        wr(8'h24, 32'h4);          // split, not released
        tick(5);
        rd(8'h10, v); check("R3 unreleased frozen", v, 0);
        wr(8'h24, 32'h1);          // released, wide mode
        tick(5);
        rd(8'h10, v); check("R3 mode0 frozen", v, 0);
        wr(8'h24, 32'hD);          // chained
        tick(5);
        rd(8'h10, v); check("R3 mode3 frozen", v, 0);
        wr(8'h24, 32'h5);          // split + released
        tick(5);
        rd(8'h10, v); check("R3 counts", v, 5);
        wr(8'h20, 32'hC0);         // reserved enable value
        rd(8'h10, v);
        tick(4);
        begin
            logic [31:0] w;
            rd(8'h10, w); check("R8 enable 3 stops", w, v);
        end
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        do_reset();
        wr(8'h18, 32'd3);
        wr(8'h24, 32'h5);
        wr(8'h20, 32'h80);
        tick(3);
        check("R4 no early irq", {31'b0, irq_lo}, 0);
        tick(1);
        check("R4 irq", {31'b0, irq_lo}, 1);
        rd(8'h10, v); check("R4 reload", v, 0);
        tick(1);
        check("R4 one cycle", {31'b0, irq_lo}, 0);
        tick(3);
        check("R4 second irq", {31'b0, irq_lo}, 1);
        check("R9 upper quiet", {31'b0, irq_hi}, 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        do_reset();
        wr(8'h1C, 32'd4);
        wr(8'h24, 32'h6);
        wr(8'h20, 32'h0040_0000);
        tick(5);
        check("R5 irq", {31'b0, irq_hi}, 1);
        rd(8'h14, v); check("R5 holds at period", v, 4);
        rd(8'h20, v); check("R5 field cleared", v, 0);
        tick(3);
        check("R5 single pulse", {31'b0, irq_hi}, 0);
        rd(8'h14, v); check("R5 still held", v, 4);
        rd(8'h10, v); check("R9 lower untouched", v, 0);
    endtask

    task automatic t_freerun_and_load();
        logic [31:0] v;
        do_reset();
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFD);
        rd(8'h10, v); check("R7 counter load", v, 32'hFFFF_FFFD);
        wr(8'h1C, 32'd1000);
        wr(8'h24, 32'h7);
        wr(8'h20, 32'h0080_0080);
        tick(2);
        rd(8'h10, v); check("R6 at max", v, 32'hFFFF_FFFF);
        tick(1);
        rd(8'h10, v); check("R6 wrap", v, 0);
        tick(1);
        rd(8'h10, v); check("R6 continues", v, 1);
        rd(8'h14, v); check("R9 upper independent", v, 4);
        wr(8'h14, 32'd0);
        rd(8'h14, v); check("R7 live load upper", v, 0);
        rd(8'h10, v); check("R9 lower unaffected", v, 2);
    endtask

    initial begin
        t_reset();
        t_map();
        t_gate();
        t_periodic();
        t_oneshot();
        t_freerun_and_load();
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule